// File: doc/BRIEF.md
# Processor Idle-State Clock Sequencer

This block moves a processor core between three power states: running (C0), halted (C1) and stop-grant (C2). It drives an active-low stop-clock output that freezes the core's instruction stream while the core is in C1 or C2. The core asks for C1 by reporting that it executed a halt instruction. It asks for C2 by reading the dedicated C2-entry register. If both requests arrive in the same cycle, C2 wins.

Any qualified break event returns the core to C0. The break sources are:
- interrupt lines, each with its own mask bit;
- NMI/SMI triggers;
- INIT triggers, including a keyboard-controller reset request;
- an RTC interrupt, gated by its own enable;
- the core's active-low pending-break line, gated by its own enable;
- an external return-to-C0 message.

On each transition the block emits single-cycle pulses: a stop-grant pulse on entry to either idle state, a C2 acknowledge on entry to C2, and a C0 acknowledge on every return to C0. All transitions are registered and take effect one clock after the cause is sampled.

Top module: `cstate_seq`

## Requirements
- R1: While reset is asserted and after it is released, the state is C0 and `stpclk_no` is 1. The pulses `stop_grant_o`, `ack_c2_o` and `ack_c0_o` are 0. `cstate_o` encodes C0=0, C1=1, C2=2.
- R2: In C0, a `halt_i` sample without `c2_rd_i` moves the block to C1 on the next cycle. In that cycle `stpclk_no` is 0 and `stop_grant_o` pulses for one cycle, while `ack_c2_o` stays 0.
- R3: In C0, a `c2_rd_i` sample moves the block to C2 on the next cycle. In that cycle `stpclk_no` is 0, and both `stop_grant_o` and `ack_c2_o` pulse for exactly one cycle.
- R4: `halt_i` and `c2_rd_i` sampled together in C0 lead to C2, not C1.
- R5: In C1 or C2, interrupt line k breaks only when it is high and `irq_mask_i[k]` is 0. Lines at index 16 and above count only when `apic_mode_i` is 1. A break returns the block to C0 on the next cycle, with `stpclk_no`=1 and a one-cycle `ack_c0_o`.
- R6: `nmi_smi_i`, `init_i` and `kbc_rst_i` are each unconditional break sources.
- R7: `rtc_irq_i` breaks only while `rtc_brk_en_i` is 1.
- R8: The pending-break line `pbe_ni` (low means pending) breaks only while `pbe_en_i` is 1.
- R9: `req_c0_i` breaks from C1 or C2. In C0 it has no effect: the block gives no `ack_c0_o` and does not change state.
- R10: If a break source is already active when entry is requested, the block spends one cycle in the idle state and then returns to C0.
- R11: In C1 or C2, with no break, the state holds and new `halt_i` or `c2_rd_i` samples are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| halt_i | input | 1 | core executed a halt instruction |
| c2_rd_i | input | 1 | read strobe of the C2-entry register |
| irq_i | input | NUM_IRQ | interrupt request lines |
| irq_mask_i | input | NUM_IRQ | per-line mask, 1 = masked |
| apic_mode_i | input | 1 | 1 enables lines at index LEGACY_IRQ and above |
| nmi_smi_i | input | 1 | NMI/SMI trigger |
| init_i | input | 1 | INIT trigger |
| kbc_rst_i | input | 1 | keyboard-controller reset request |
| rtc_irq_i | input | 1 | RTC interrupt |
| rtc_brk_en_i | input | 1 | RTC break enable |
| pbe_ni | input | 1 | pending-break indication, active low |
| pbe_en_i | input | 1 | pending-break enable |
| req_c0_i | input | 1 | return-to-C0 message |
| stpclk_no | output | 1 | stop-clock, active low |
| stop_grant_o | output | 1 | one-cycle pulse on entry to C1 or C2 |
| ack_c2_o | output | 1 | one-cycle C2 acknowledge |
| ack_c0_o | output | 1 | one-cycle C0 acknowledge |
| cstate_o | output | 2 | current state, C0=0, C1=1, C2=2 |

## Verification
The bench runs a behavioural model next to the block and targets the following corner cases.

- **Simultaneous entry requests.** A design that favoured halt when both requests arrive together would land in C1 and never raise the C2 acknowledge.
- **Gated sources.** Masked lines, high lines while legacy mode is selected, and the RTC and pending-break inputs with their enables clear are all held active for several cycles. A design that leaked any of them would wake the core early.
- **Return-to-C0 message in C0.** Sending the message while already running would produce a stray C0 acknowledge in a wrong design.
- **Break active at entry.** Entering with a break already active must cost exactly one idle cycle.
- **Entry requests while idle.** Repeated entry requests in an idle state must not re-pulse the stop-grant output.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  localparam int STW = 2;
  typedef enum logic [STW-1:0] {
    ST_C0 = 2'd0,
    ST_C1 = 2'd1,
    ST_C2 = 2'd2
  } cstate_e;
endpackage

// File: rtl/cstate_brk_agg.sv
module cstate_brk_agg #(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               apic_mode_i,
  input  logic               nmi_smi_i,
  input  logic               init_i,
  input  logic               kbc_rst_i,
  input  logic               rtc_irq_i,
  input  logic               rtc_brk_en_i,
  input  logic               pbe_ni,
  input  logic               pbe_en_i,
  input  logic               req_c0_i,
  output logic               brk_o
);
  logic [NUM_IRQ-1:0] line_live;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    if (k < LEGACY_IRQ) begin : g_leg
      assign line_live[k] = irq_i[k] & ~irq_mask_i[k];
    end else begin : g_ext
      assign line_live[k] = irq_i[k] & ~irq_mask_i[k] & apic_mode_i;
    end
  end

  logic misc_brk;
  assign misc_brk = nmi_smi_i | init_i | kbc_rst_i | req_c0_i
                  | (rtc_irq_i & rtc_brk_en_i) | (~pbe_ni & pbe_en_i);
  assign brk_o = (|line_live) | misc_brk;

  // gated sources alone never raise a break
  p_gated_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_smi_i && !init_i && !kbc_rst_i && !req_c0_i && !rtc_brk_en_i
     && !pbe_en_i && ((irq_i & ~irq_mask_i) == '0)) |-> !brk_o);
  p_unconditional_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_smi_i || init_i || kbc_rst_i) |-> brk_o);
endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
  import cstate_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           halt_i,
  input  logic           c2_rd_i,
  input  logic           brk_i,
  output cstate_e        state_o,
  output logic           stop_grant_o,
  output logic           ack_c2_o,
  output logic           ack_c0_o
);
  cstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_C0: begin
        if (c2_rd_i)     state_d = ST_C2;
        else if (halt_i) state_d = ST_C1;
      end
      ST_C1, ST_C2: if (brk_i) state_d = ST_C0;
      default: state_d = ST_C0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_C0;
      stop_grant_o <= 1'b0;
      ack_c2_o     <= 1'b0;
      ack_c0_o     <= 1'b0;
    end else begin
      state_q      <= state_d;
      stop_grant_o <= (state_q == ST_C0) && (state_d != ST_C0);
      ack_c2_o     <= (state_q == ST_C0) && (state_d == ST_C2);
      ack_c0_o     <= (state_q != ST_C0) && (state_d == ST_C0);
    end
  end

  assign state_o = state_q;

  p_c2_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C0 && c2_rd_i && halt_i) |=> (state_q == ST_C2));
  p_enter_c1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C0 && halt_i && !c2_rd_i) |=> (state_q == ST_C1 && stop_grant_o && !ack_c2_o));
  p_ack_c2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_c2_o |-> (state_q == ST_C2 && stop_grant_o));
  p_break_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_C0 && brk_i) |=> (state_q == ST_C0 && ack_c0_o));
  p_ack_c0_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_c0_o |=> !ack_c0_o);
  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_C0 && !brk_i) |=> ($stable(state_q) && !stop_grant_o));
  p_pulses_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stop_grant_o, ack_c0_o}));
endmodule

// File: rtl/cstate_seq.sv
module cstate_seq
  import cstate_pkg::*;
#(
  parameter int NUM_IRQ    = 24,
  parameter int LEGACY_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_i,
  input  logic               c2_rd_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               apic_mode_i,
  input  logic               nmi_smi_i,
  input  logic               init_i,
  input  logic               kbc_rst_i,
  input  logic               rtc_irq_i,
  input  logic               rtc_brk_en_i,
  input  logic               pbe_ni,
  input  logic               pbe_en_i,
  input  logic               req_c0_i,
  output logic               stpclk_no,
  output logic               stop_grant_o,
  output logic               ack_c2_o,
  output logic               ack_c0_o,
  output logic [STW-1:0]     cstate_o
);
  logic    brk;
  cstate_e state;

  cstate_brk_agg #(.NUM_IRQ(NUM_IRQ), .LEGACY_IRQ(LEGACY_IRQ)) u_agg (
    .clk_i, .rst_ni, .irq_i, .irq_mask_i, .apic_mode_i, .nmi_smi_i,
    .init_i, .kbc_rst_i, .rtc_irq_i, .rtc_brk_en_i, .pbe_ni, .pbe_en_i,
    .req_c0_i, .brk_o(brk)
  );

  cstate_fsm u_fsm (
    .clk_i, .rst_ni, .halt_i, .c2_rd_i, .brk_i(brk), .state_o(state),
    .stop_grant_o, .ack_c2_o, .ack_c0_o
  );

  assign stpclk_no = (state == ST_C0);
  assign cstate_o  = state;

  // return-to-C0 message while running: no acknowledge
  p_req_c0_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_C0 && req_c0_i) |=> !ack_c0_o);
  p_stpclk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stpclk_no) |-> ack_c0_o);
endmodule

// File: tb/cstate_seq_test.sv
module cstate_seq_test;
  localparam int NI = 24;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 0, c2rd = 0, apic = 0, nmi = 0, ini = 0, kbc = 0;
  logic rtc = 0, rtc_en = 0, pbe_n = 1, pbe_en = 0, reqc0 = 0;
  logic [NI-1:0] irq = '0, mask = '0;
  logic stp_n, sg, a2, a0;
  logic [1:0] st;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R1";

  int e_st = 0;
  logic e_sg = 0, e_a2 = 0, e_a0 = 0;

  always #4 clk = ~clk;

  cstate_seq #(.NUM_IRQ(NI), .LEGACY_IRQ(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .c2_rd_i(c2rd),
    .irq_i(irq), .irq_mask_i(mask), .apic_mode_i(apic), .nmi_smi_i(nmi),
    .init_i(ini), .kbc_rst_i(kbc), .rtc_irq_i(rtc), .rtc_brk_en_i(rtc_en),
    .pbe_ni(pbe_n), .pbe_en_i(pbe_en), .req_c0_i(reqc0),
    .stpclk_no(stp_n), .stop_grant_o(sg), .ack_c2_o(a2), .ack_c0_o(a0),
    .cstate_o(st)
  );

  function automatic bit model_brk();
    bit b = nmi || ini || kbc || reqc0 || (rtc && rtc_en) || (!pbe_n && pbe_en);
    for (int k = 0; k < NI; k++)
      if (irq[k] && !mask[k] && (apic || k < NL)) b = 1;
    return b;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_st = 0; e_sg = 0; e_a2 = 0; e_a0 = 0;
    end else begin
      e_sg = 0; e_a2 = 0; e_a0 = 0;
      if (e_st == 0) begin
        if (c2rd) begin e_st = 2; e_sg = 1; e_a2 = 1; end
        else if (halt) begin e_st = 1; e_sg = 1; end
      end else if (model_brk()) begin
        e_st = 0; e_a0 = 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [4:0] act, exp_v;
    act   = {st, stp_n, sg, a2} ^ 5'b0;
    exp_v = {2'(e_st), (e_st == 0), e_sg, e_a2};
    checks++;
    if (act !== exp_v || a0 !== e_a0) begin
      errors++;
      $display("FAIL %s: {st,stp_n,sg,a2,a0} act=%b_%b exp=%b_%b at %0t",
               cur_req, act, a0, exp_v, e_a0, $time);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_c2();
    c2rd = 1; cyc(1); c2rd = 0; cyc(2);
  endtask

  initial begin
    cur_req = "R1"; cyc(3); rst_n = 1; cyc(3);
    // R2 halt -> C1, R11 entry while idle ignored, R5 break
    cur_req = "R2"; halt = 1; cyc(1); halt = 0; cyc(3);
    cur_req = "R11"; c2rd = 1; halt = 1; cyc(2); c2rd = 0; halt = 0; cyc(2);
    cur_req = "R5"; irq[3] = 1; cyc(1); irq[3] = 0; cyc(2);
    // R3 C2 entry, masked and legacy-gated lines
    cur_req = "R3"; go_c2();
    cur_req = "R5"; mask[1] = 1; irq[1] = 1; cyc(3); irq[1] = 0; mask[1] = 0;
    irq[20] = 1; cyc(3); apic = 1; cyc(2); irq[20] = 0; apic = 0; cyc(2);
    // R4 simultaneous requests
    cur_req = "R4"; halt = 1; c2rd = 1; cyc(1); halt = 0; c2rd = 0; cyc(2);
    cur_req = "R6"; nmi = 1; cyc(1); nmi = 0; cyc(1);
    go_c2(); ini = 1; cyc(1); ini = 0; cyc(1);
    halt = 1; cyc(1); halt = 0; cyc(1); kbc = 1; cyc(1); kbc = 0; cyc(2);
    // R7 RTC gating
    cur_req = "R7"; go_c2(); rtc = 1; cyc(3); rtc_en = 1; cyc(2); rtc = 0; rtc_en = 0; cyc(1);
    // R8 pending-break gating
    cur_req = "R8"; go_c2(); pbe_n = 0; cyc(3); pbe_en = 1; cyc(2); pbe_n = 1; pbe_en = 0; cyc(1);
    // R9 message ignored in C0, honoured when idle
    cur_req = "R9"; reqc0 = 1; cyc(3); reqc0 = 0; cyc(1);
    halt = 1; cyc(1); halt = 0; cyc(2); reqc0 = 1; cyc(1); reqc0 = 0; cyc(2);
    go_c2(); reqc0 = 1; cyc(2); reqc0 = 0; cyc(2);
    // R10 break already active at entry
    cur_req = "R10"; nmi = 1; c2rd = 1; cyc(1); c2rd = 0; cyc(3);
    halt = 1; cyc(1); halt = 0; cyc(2); nmi = 0; cyc(2);
    cur_req = "R1"; rst_n = 0; cyc(2); rst_n = 1; cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule